// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Port

This block connects an external host processor to an internal core through an 8-bit data bus. The host moves 16-bit words one byte at a time into an input register and out of an output register. The core writes the output register and reads the input register through its own 16-bit data paths, each with a one-cycle pulse.

Two handshake flags let each side pace its transfers. The input-full flag is set when a host write ends and is cleared when the core reads. The output-empty flag is set when a host read ends and is cleared when the core writes.

The host may use either of two bus styles, chosen on the core side:
- **Split-strobe style:** separate active-low write and read strobes.
- **Shared-strobe style:** one direction line plus one data strobe, whose active level is also configurable.

All host control pins pass through synchronisers into the core clock. Every host access ends at whichever of its strobe or its chip select goes inactive first. The host must keep its data and byte select stable until that end has been seen by the core clock.

Top module: `hpp_host_port`

## Requirements
- R1: After reset, flag_in_full is 0, flag_out_empty is 1, host_d_oe is 0 and the input register holds 0.
- R2: While host_cs_n is high, no activity on host_stb_a or host_stb_b changes either flag, the input register or host_d_oe.
- R3: host_bsel = 1 targets bits [15:8] of a register and host_bsel = 0 targets bits [7:0], for host writes and host reads alike.
- R4: During a host read, host_stat = 0 drives the selected byte of the output register. host_stat = 1 drives the status byte {6'b0, out_empty, in_full}, with in_full in bit 0 and out_empty in bit 1.
- R5: With cfg_combined = 0, host_stb_a is an active-low write strobe. The byte on host_d_in is stored when host_stb_a or host_cs_n rises, whichever rises first.
- R6: With cfg_combined = 0, host_stb_b low while host_cs_n is low drives host_d_oe to 1 combinationally, and the selected byte appears on host_d_out.
- R7: With cfg_combined = 1, host_stb_a is a direction line (0 means write, 1 means read), and host_stb_b is the data strobe for both directions. The strobe is active high when cfg_ds_high = 1 and active low when cfg_ds_high = 0.
- R8: The internal input-full flag is set on the third rising clock edge after a host write ends. A core_rd pulse clears it on the next edge. If the set and the clear land on the same edge, the set wins.
- R9: The output-empty flag is set on the third rising clock edge after a host read ends. A core_wr pulse clears it on the next edge. If the set and the clear land on the same edge, the set wins.
- R10: flag_in_full carries in_full when cfg_merge = 0, and carries in_full OR out_empty when cfg_merge = 1.
- R11: core_rdata always shows the input register. A core_wr pulse loads core_wdata into the output register, which otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_bsel | input | 1 | Byte select: 1 selects the high byte, 0 the low byte |
| host_stat | input | 1 | Status select for host reads |
| host_stb_a | input | 1 | Write strobe, or the direction line in shared-strobe style |
| host_stb_b | input | 1 | Read strobe, or the data strobe in shared-strobe style |
| host_d_in | input | 8 | Host data into the port |
| host_d_out | output | 8 | Host data out of the port |
| host_d_oe | output | 1 | Output enable for host_d_out; the bus is tri-stated when low |
| core_wdata | input | 16 | Core data for the output register |
| core_wr | input | 1 | Core write pulse |
| core_rdata | output | 16 | Input register contents |
| core_rd | input | 1 | Core read pulse; marks the input register as consumed |
| cfg_combined | input | 1 | 1 selects shared-strobe style |
| cfg_ds_high | input | 1 | Active level of the data strobe in shared-strobe style |
| cfg_merge | input | 1 | Merge output-empty into flag_in_full |
| flag_in_full | output | 1 | Input-full flag pin, possibly merged |
| flag_out_empty | output | 1 | Output-empty flag |

## Verification
The read path is combinational from the pins, so host_d_oe and host_d_out are checked 1 ns after the read strobe asserts. A host strobe or chip-select change takes effect on the third rising edge after it, because of two synchroniser stages and one flag register. For that reason the bench changes host pins on a falling edge, checks that the flag is still unchanged one falling edge after the second rising edge, and checks that it has changed one falling edge after the third. Core pulses act on the next edge and are checked at the following falling edge. A directed case lines a core pulse up with that third edge to exercise the set-wins priority of each flag.

// File: rtl/hpp_pkg.sv
package hpp_pkg;

   // synchronised host control pins, one bit each
   typedef struct packed {
      logic cs_n;
      logic stb_a;
      logic stb_b;
   } hpp_ctl_t;

   localparam hpp_ctl_t HPP_CTL_IDLE = '{cs_n: 1'b1, stb_a: 1'b1, stb_b: 1'b1};

   // data strobe is active when its level matches the configured polarity
   function automatic logic hpp_ds_on(input logic lvl, input logic active_high);
      return (lvl == active_high);
   endfunction

endpackage

// File: rtl/hpp_sync.sv
module hpp_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [31:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("hpp_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL[WIDTH-1:0];
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL[WIDTH-1:0];
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hpp_strobe_dec.sv
module hpp_strobe_dec
   import hpp_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  hpp_ctl_t ctl_s,
   input  logic     cfg_combined,
   input  logic     cfg_ds_high,
   output logic     wr_done,
   output logic     rd_done
);

   logic ds_on;
   logic wr_act, rd_act;
   logic wr_act_q, rd_act_q;

   always_comb begin
      ds_on = hpp_ds_on(ctl_s.stb_b, cfg_ds_high);
      if (cfg_combined) begin
         wr_act = !ctl_s.cs_n && !ctl_s.stb_a && ds_on;
         rd_act = !ctl_s.cs_n &&  ctl_s.stb_a && ds_on;
      end else begin
         wr_act = !ctl_s.cs_n && !ctl_s.stb_a;
         rd_act = !ctl_s.cs_n && !ctl_s.stb_b;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_act_q <= 1'b0;
         rd_act_q <= 1'b0;
      end else begin
         wr_act_q <= wr_act;
         rd_act_q <= rd_act;
      end
   end

   // access ends when strobe or select leaves the active state, whichever is first
   assign wr_done = wr_act_q && !wr_act;
   assign rd_done = rd_act_q && !rd_act;

   // R2
   cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_s.cs_n && $past(ctl_s.cs_n)) |-> (!wr_done && !rd_done));

endmodule

// File: rtl/hpp_regs.sv
module hpp_regs #(
   parameter int BUS_W  = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_done,
   input  logic              rd_done,
   input  logic              host_bsel,
   input  logic [BUS_W-1:0]  host_d_in,
   input  logic              core_wr,
   input  logic [DATA_W-1:0] core_wdata,
   input  logic              core_rd,
   output logic [DATA_W-1:0] in_reg,
   output logic [DATA_W-1:0] out_reg,
   output logic              in_full,
   output logic              out_empty
);

   localparam int LANES = DATA_W / BUS_W;

   if (LANES != 2 || DATA_W % BUS_W != 0) begin : g_bad_width
      $error("hpp_regs: DATA_W must be exactly twice BUS_W");
   end

   // one byte lane per byte select value
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            in_reg[l*BUS_W +: BUS_W] <= '0;
         else if (wr_done && (int'(host_bsel) == l))
            in_reg[l*BUS_W +: BUS_W] <= host_d_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_reg   <= '0;
         in_full   <= 1'b0;
         out_empty <= 1'b1;
      end else begin
         if (core_wr) out_reg <= core_wdata;
         // host events take priority over core clears
         if (wr_done)      in_full <= 1'b1;
         else if (core_rd) in_full <= 1'b0;
         if (rd_done)      out_empty <= 1'b1;
         else if (core_wr) out_empty <= 1'b0;
      end
   end

   // R8
   in_full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> in_full);
   // R8
   in_full_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rd && !wr_done) |=> !in_full);
   // R9
   out_empty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> out_empty);
   // R9
   out_empty_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_wr && !rd_done) |=> !out_empty);
   // R11
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !core_wr |=> $stable(out_reg));

endmodule

// File: rtl/hpp_host_port.sv
module hpp_host_port
   import hpp_pkg::*;
#(
   parameter int BUS_W       = 8,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs_n,
   input  logic              host_bsel,
   input  logic              host_stat,
   input  logic              host_stb_a,
   input  logic              host_stb_b,
   input  logic [BUS_W-1:0]  host_d_in,
   output logic [BUS_W-1:0]  host_d_out,
   output logic              host_d_oe,
   input  logic [DATA_W-1:0] core_wdata,
   input  logic              core_wr,
   output logic [DATA_W-1:0] core_rdata,
   input  logic              core_rd,
   input  logic              cfg_combined,
   input  logic              cfg_ds_high,
   input  logic              cfg_merge,
   output logic              flag_in_full,
   output logic              flag_out_empty
);

   localparam int CTL_W = $bits(hpp_ctl_t);

   if (BUS_W < 2) begin : g_bad_bus
      $error("hpp_host_port: BUS_W must hold the two status bits");
   end

   hpp_ctl_t          ctl_raw, ctl_s;
   logic              wr_done, rd_done;
   logic [DATA_W-1:0] in_reg, out_reg;
   logic              in_full, out_empty;
   logic              rd_pin;
   logic [BUS_W-1:0]  status_byte;

   assign ctl_raw = '{cs_n: host_cs_n, stb_a: host_stb_a, stb_b: host_stb_b};

   hpp_sync #(
      .WIDTH   (CTL_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (32'(HPP_CTL_IDLE))
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctl_raw),
      .q     (ctl_s)
   );

   hpp_strobe_dec i_dec (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl_s        (ctl_s),
      .cfg_combined (cfg_combined),
      .cfg_ds_high  (cfg_ds_high),
      .wr_done      (wr_done),
      .rd_done      (rd_done)
   );

   hpp_regs #(
      .BUS_W  (BUS_W),
      .DATA_W (DATA_W)
   ) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_done    (wr_done),
      .rd_done    (rd_done),
      .host_bsel  (host_bsel),
      .host_d_in  (host_d_in),
      .core_wr    (core_wr),
      .core_wdata (core_wdata),
      .core_rd    (core_rd),
      .in_reg     (in_reg),
      .out_reg    (out_reg),
      .in_full    (in_full),
      .out_empty  (out_empty)
   );

   // read path works straight from the pins so data is ready while the strobe is held
   always_comb begin
      if (cfg_combined)
         rd_pin = host_stb_a && hpp_ds_on(host_stb_b, cfg_ds_high);
      else
         rd_pin = !host_stb_b;
      status_byte    = '0;
      status_byte[0] = in_full;
      status_byte[1] = out_empty;
   end

   assign host_d_oe      = !host_cs_n && rd_pin;
   assign host_d_out     = host_stat ? status_byte
                         : (host_bsel ? out_reg[DATA_W-1 -: BUS_W] : out_reg[BUS_W-1:0]);
   assign core_rdata     = in_reg;
   assign flag_in_full   = in_full || (cfg_merge && out_empty);
   assign flag_out_empty = out_empty;

   // R6
   oe_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_d_oe |-> !host_cs_n);
   // R10
   merge_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_merge |-> (flag_in_full == in_full));

endmodule

// File: tb/test_hpp_host_port.sv
`timescale 1ns/1ps
module test_hpp_host_port;

   localparam time CYC = 4ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_cs_n = 1'b1, host_bsel = 1'b0, host_stat = 1'b0;
   logic        host_stb_a = 1'b1, host_stb_b = 1'b1;
   logic [7:0]  host_d_in = '0;
   logic [7:0]  host_d_out;
   logic        host_d_oe;
   logic [15:0] core_wdata = '0;
   logic        core_wr = 1'b0, core_rd = 1'b0;
   logic [15:0] core_rdata;
   logic        cfg_combined = 1'b0, cfg_ds_high = 1'b0, cfg_merge = 1'b0;
   logic        flag_in_full, flag_out_empty;

   int n_chk = 0, n_fail = 0;
   logic [15:0] m_in = '0, m_out = '0;
   logic        m_full = 1'b0, m_empty = 1'b1;

   always #(CYC/2) clk = ~clk;

   hpp_host_port i_hpp_host_port (
      .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_bsel(host_bsel),
      .host_stat(host_stat), .host_stb_a(host_stb_a), .host_stb_b(host_stb_b),
      .host_d_in(host_d_in), .host_d_out(host_d_out), .host_d_oe(host_d_oe),
      .core_wdata(core_wdata), .core_wr(core_wr), .core_rdata(core_rdata),
      .core_rd(core_rd), .cfg_combined(cfg_combined), .cfg_ds_high(cfg_ds_high),
      .cfg_merge(cfg_merge), .flag_in_full(flag_in_full), .flag_out_empty(flag_out_empty));

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input logic stat, input logic bsel);
      if (stat) return {6'b0, m_empty, m_full};
      return bsel ? m_out[15:8] : m_out[7:0];
   endfunction

   function automatic logic exp_pin_full();
      return m_full | (cfg_merge & m_empty);
   endfunction

   task automatic check_flags(input string tag);
      check({tag, " flag_in_full"}, {15'b0, flag_in_full}, {15'b0, exp_pin_full()});
      check({tag, " flag_out_empty"}, {15'b0, flag_out_empty}, {15'b0, m_empty});
   endtask

   task automatic settle2();   // after second rising edge
      repeat (2) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_idle();
      host_cs_n  = 1'b1;
      host_stb_a = 1'b1;
      host_stb_b = cfg_combined ? ~cfg_ds_high : 1'b1;
   endtask

   // R5 R7 R8: host write of one byte; clash lines a core_rd up with the setting edge
   task automatic host_write(input logic bsel, input logic [7:0] d, input logic cs_first,
                             input logic clash);
      host_bsel = bsel; host_d_in = d; host_cs_n = 1'b0; host_stb_a = 1'b0;
      if (cfg_combined) host_stb_b = cfg_ds_high;
      repeat (4) @(negedge clk);
      if (cs_first) host_cs_n = 1'b1;
      else if (cfg_combined) host_stb_b = ~cfg_ds_high;
      else host_stb_a = 1'b1;
      settle2();
      check("R8 in_full not yet set", {15'b0, flag_in_full}, {15'b0, exp_pin_full()});
      if (clash) core_rd = 1'b1;
      @(posedge clk); @(negedge clk);
      core_rd = 1'b0;
      if (bsel) m_in[15:8] = d; else m_in[7:0] = d;
      m_full = 1'b1;
      check_flags(clash ? "R8 set wins over core_rd" : "R8 write end");
      check(cfg_combined ? "R7 combined write data" : "R5 write data", core_rdata, m_in);
      set_idle();
      @(negedge clk);
   endtask

   // R4 R6 R7 R9: host read; clash lines a core_wr up with the setting edge
   task automatic host_read(input logic bsel, input logic stat, input logic cs_first,
                            input logic clash, input logic [15:0] wd);
      host_bsel = bsel; host_stat = stat; host_cs_n = 1'b0;
      if (cfg_combined) begin host_stb_a = 1'b1; host_stb_b = cfg_ds_high; end
      else host_stb_b = 1'b0;
      #1;
      check(cfg_combined ? "R7 read oe" : "R6 read oe", {15'b0, host_d_oe}, 16'd1);
      check(stat ? "R4 status byte" : "R3 read byte", {8'b0, host_d_out},
            {8'b0, exp_byte(stat, bsel)});
      repeat (3) @(negedge clk);
      if (cs_first) host_cs_n = 1'b1;
      else if (cfg_combined) host_stb_b = ~cfg_ds_high;
      else host_stb_b = 1'b1;
      settle2();
      check("R9 out_empty not yet set", {15'b0, flag_out_empty}, {15'b0, m_empty});
      if (clash) begin core_wr = 1'b1; core_wdata = wd; end
      @(posedge clk); @(negedge clk);
      core_wr = 1'b0;
      if (clash) m_out = wd;
      m_empty = 1'b1;
      check_flags(clash ? "R9 set wins over core_wr" : "R9 read end");
      set_idle();
      #1;
      check("R6 oe off after read", {15'b0, host_d_oe}, 16'd0);
      @(negedge clk);
   endtask

   task automatic core_write(input logic [15:0] wd);
      core_wr = 1'b1; core_wdata = wd;
      @(negedge clk);
      core_wr = 1'b0;
      m_out = wd; m_empty = 1'b0;
      check_flags("R9 core_wr clears");
   endtask

   task automatic core_read();
      check("R11 core_rdata", core_rdata, m_in);
      core_rd = 1'b1;
      @(negedge clk);
      core_rd = 1'b0;
      m_full = 1'b0;
      check_flags("R8 core_rd clears");
   endtask

   task automatic set_mode(input logic comb, input logic dsh, input logic mrg);
      cfg_combined = comb; cfg_ds_high = dsh; cfg_merge = mrg;
      set_idle();
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CYC * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int unsigned seed_val;
      seed_val = $urandom(32'd4519);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1 reset in_full", {15'b0, flag_in_full}, 16'd0);
      check("R1 reset out_empty", {15'b0, flag_out_empty}, 16'd1);
      check("R1 reset oe", {15'b0, host_d_oe}, 16'd0);
      check("R1 reset input reg", core_rdata, 16'h0000);

      // R5 R3 split style, both byte lanes, both endings
      host_write(1'b0, 8'hA5, 1'b0, 1'b0);
      host_write(1'b1, 8'h3C, 1'b1, 1'b0);
      core_read();
      core_write(16'hBEEF);
      host_read(1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
      host_read(1'b0, 1'b1, 1'b1, 1'b0, 16'h0);

      // R2 strobes with chip select high
      repeat (6) begin
         host_stb_a = ~host_stb_a; host_stb_b = ~host_stb_b; host_d_in = 8'hFF;
         #1;
         check("R2 oe while deselected", {15'b0, host_d_oe}, 16'd0);
         @(negedge clk);
      end
      set_idle();
      repeat (4) @(negedge clk);
      check_flags("R2 flags after deselected strobes");
      check("R2 input reg unchanged", core_rdata, m_in);

      // R10 merge
      set_mode(1'b0, 1'b0, 1'b1);
      check_flags("R10 merged flag");
      core_write(16'h1234);
      check_flags("R10 merged after core_wr");

      // R7 combined style, both strobe levels
      set_mode(1'b1, 1'b1, 1'b0);
      host_write(1'b1, 8'h5A, 1'b0, 1'b0);
      host_read(1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
      set_mode(1'b1, 1'b0, 1'b0);
      host_write(1'b0, 8'hC3, 1'b1, 1'b0);
      core_write(16'h00F0);
      host_read(1'b1, 1'b0, 1'b1, 1'b0, 16'h0);

      // R8 R9 same-edge priority
      core_read();
      host_write(1'b0, 8'h77, 1'b0, 1'b1);
      core_write(16'h4242);
      host_read(1'b0, 1'b0, 1'b0, 1'b1, 16'h9999);

      // random mix
      for (int i = 0; i < 300; i++) begin
         int unsigned op;
         op = $urandom_range(0, 5);
         case (op)
            0: host_write(1'($urandom), 8'($urandom), 1'($urandom), 1'b0);
            1: host_read(1'($urandom), 1'($urandom), 1'($urandom), 1'b0, 16'h0);
            2: core_write(16'($urandom));
            3: core_read();
            4: set_mode(1'($urandom), 1'($urandom), 1'($urandom));
            default: begin
               host_write(1'($urandom), 8'($urandom), 1'($urandom), 1'b1);
               host_read(1'($urandom), 1'($urandom), 1'($urandom), 1'b1, 16'($urandom));
            end
         endcase
      end
      finish_run();
   end

endmodule